// File: doc/BRIEF.md
# I2C Register-Bank Target with Auto-Increment

This block is a synchronous I2C target that holds nine 8-bit configuration registers for a clock-generation chip. A fast system clock oversamples the SCL and SDA lines. The block detects START and STOP conditions and compares the first byte of each session against its own 7-bit device address. In a write session the next byte sets a register pointer and every later byte is stored at that pointer, after which the pointer advances by one. In a read session the block returns the register at the pointer and each register after it, in order. Past the last register it returns a fixed filler byte.

The device address has a fixed upper nibble. The lower three bits come from two three-level strap inputs, which give eight addresses. The strap combination with both inputs high hands the control port to another serial engine, and this block then stays silent. Two event inputs set sticky flags in one register, and those flags drive an interrupt output. A master-reset input and a self-clearing soft-reset bit both return the bank to its default values.

Top module: `i2cr_target_bank`

## Requirements
- R1: The device address is {1101, idx}, where idx = 3*L(strap_hi) + L(strap_lo). The level code L is 0 for strap code 00 (low), 2 for 10 (high), and 1 for 01 (open) or 11. The block pulls SDA low in the ninth clock only for a matching address.
- R2: With strap_hi = strap_lo = 10, the block never asserts sda_oe and acknowledges no address.
- R3: A START (SDA falling while SCL is high) begins address reception from any state. A repeated START keeps the register pointer. A STOP (SDA rising while SCL is high) returns the block to idle, and bits clocked after a STOP with no new START are ignored.
- R4: In a write session the byte after the address loads the pointer and is acknowledged only if it is below 9. A pointer byte of 9 or more is not acknowledged, and the block ignores the rest of that session.
- R5: Each data byte in a write session is stored at the pointer and acknowledged, and the pointer then advances by one. Register k appears on cfg_o[8k+7:8k].
- R6: Once the pointer has passed register 8, further data bytes are not acknowledged and no register changes.
- R7: A read session returns the register at the pointer and then the following registers, as long as the master acknowledges each byte. A master NACK ends the stream. Any byte past register 8 reads as 0xFF.
- R8: While rst_n is low or mrst is high, every register k takes its default value 0x80+k.
- R9: Writing a byte with bit 4 set to register 6 returns every register to its default on the next clock.
- R10: Register 7 bits 5 and 6 are sticky flags. evt_i[0] sets bit 5 and evt_i[1] sets bit 6. Writing 1 to a flag bit clears it, and the other bits of register 7 take the written value. irq_o is the OR of the two flags and stays low while mrst is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| mrst | input | 1 | Master reset, active high, synchronous |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| strap_hi | input | 2 | Upper three-level strap code (00 low, 01 open, 10 high) |
| strap_lo | input | 2 | Lower three-level strap code (00 low, 01 open, 10 high) |
| evt_i | input | 2 | Event pulses that set the flags in register 7 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 72 | All registers packed, register k in bits 8k+7:8k |
| irq_o | output | 1 | Interrupt, OR of the register 7 flags |

## Verification
The bench uses the default build: nine registers, a two-flop synchronizer and the 1101 prefix. It drives SCL with a quarter-bit time of six system clocks. With nine registers, the pointer limit, the write refusal after register 8 and the 0xFF filler can all be reached in short bursts. Every strap level, including the both-high hand-over, can be tried in a few sessions. The margin between the synchronizer delay and the quarter-bit time lets the bench sample ACK and read bits at the middle of SCL high, with no race against the target's output register.

// File: rtl/i2cr_pkg.sv
// Shared types and constants for the I2C register-bank target.
// Assumes: register defaults are a pure function of the register index.
package i2cr_pkg;

    // Bus protocol phases of the target engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_MACK
    } bus_state_t;

    // Default contents of register idx: top bit set, index in low bits.
    function automatic logic [7:0] reg_default(input int unsigned idx);
        return 8'h80 | 8'(idx);
    endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
// Synchronizes SCL/SDA into the clk domain and derives SCL edges and
// START/STOP events. Assumes clk runs many times faster than SCL.
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_lvl;
    logic              scl_d;
    logic              sda_d;

    // Shift both lines through the synchronizer chain (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            for (int k = STAGES - 1; k > 0; k--) begin
                scl_sh[k] <= scl_sh[k-1];
                sda_sh[k] <= sda_sh[k-1];
            end
            scl_sh[0] <= scl_i;
            sda_sh[0] <= sda_i;
        end
    end

    assign scl_lvl = scl_sh[STAGES-1];
    assign sda_lvl = sda_sh[STAGES-1];

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_lvl;
            sda_d <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2cr_strap_decode.sv
// Turns two three-level strap codes into the 7-bit device address and
// flags the both-high combination that hands the port to another engine.
// Assumes straps are static during a session.
module i2cr_strap_decode #(
    parameter logic [3:0] PREFIX = 4'b1101
) (
    input  logic [1:0] pin_hi,
    input  logic [1:0] pin_lo,
    output logic [6:0] dev_addr,
    output logic       i2c_off
);

    // Map a strap code to its level: low 0, open 1, high 2.
    function automatic logic [3:0] level_of(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd0;
            2'b10:   return 4'd2;
            default: return 4'd1;
        endcase
    endfunction

    logic [3:0] combo;

    // Order the nine combinations by (upper, lower) level.
    always_comb begin
        combo    = level_of(pin_hi) * 4'd3 + level_of(pin_lo);
        i2c_off  = (combo == 4'd8);
        dev_addr = {PREFIX, combo[2:0]};
    end

endmodule

// File: rtl/i2cr_regfile.sv
// Bank of NREG 8-bit registers with master reset, a soft-reset bit and
// a pair of sticky write-1-to-clear event flags feeding an interrupt.
// Assumes wr_en is a single-cycle strobe from the bus engine.
module i2cr_regfile
    import i2cr_pkg::*;
#(
    parameter int NREG     = 9,
    parameter int PW       = 4,
    parameter int SRST_IDX = 6,
    parameter int SRST_BIT = 4,
    parameter int FLAG_IDX = 7,
    parameter int FLAG_LSB = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mrst,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_idx,
    input  logic [7:0]      wr_data,
    input  logic [1:0]      evt,
    output logic [NREG*8-1:0] regs_flat,
    output logic            irq
);

    localparam logic [7:0] FMASK = 8'h03 << FLAG_LSB;

    // Packed default image of the whole bank.
    function automatic logic [NREG*8-1:0] bank_defaults();
        logic [NREG*8-1:0] img;
        img = '0;
        for (int k = 0; k < NREG; k++) img[8*k +: 8] = reg_default(k);
        return img;
    endfunction

    localparam logic [NREG*8-1:0] DFLT = bank_defaults();

    logic [7:0] q [NREG];
    logic       soft_rst;
    logic       clr;
    logic [7:0] evt_bits;

    assign soft_rst = wr_en && (wr_idx == PW'(SRST_IDX)) && wr_data[SRST_BIT];
    assign clr      = !rst_n || mrst || soft_rst;
    assign evt_bits = 8'({6'b0, evt}) << FLAG_LSB;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == FLAG_IDX) begin : g_flag
            // Flag register: plain bits plus sticky, write-1-clear flags.
            always_ff @(posedge clk) begin
                if (clr)
                    q[g] <= reg_default(g);
                else if (wr_en && wr_idx == PW'(g))
                    q[g] <= (wr_data & ~FMASK) | (q[g] & FMASK & ~wr_data) | evt_bits;
                else
                    q[g] <= q[g] | evt_bits;
            end
        end else begin : g_plain
            // Plain register: load on a matching write strobe.
            always_ff @(posedge clk) begin
                if (clr)
                    q[g] <= reg_default(g);
                else if (wr_en && wr_idx == PW'(g))
                    q[g] <= wr_data;
            end
        end
        assign regs_flat[8*g +: 8] = q[g];
    end

    assign irq = |(q[FLAG_IDX] & FMASK);

    AST_MRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> regs_flat == DFLT); // R8
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == PW'(SRST_IDX) && wr_data[SRST_BIT]) |=> regs_flat == DFLT); // R9
    AST_IRQ_QUIET_IN_MRST: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> !irq); // R10

endmodule

// File: rtl/i2cr_target_bank.sv
// I2C target giving a master access to an NREG-register bank with a
// pointer that auto-increments on writes and reads. Assumes clk is at
// least ~16x the SCL rate and no clock stretching is needed.
module i2cr_target_bank
    import i2cr_pkg::*;
#(
    parameter int         NREG        = 9,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] PREFIX      = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_hi,
    input  logic [1:0]        strap_lo,
    input  logic [1:0]        evt_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] cfg_o,
    output logic              irq_o
);

    localparam int PW = $clog2(NREG + 1);

    logic          sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]    dev_addr;
    logic          i2c_off;
    logic          bus_rst;
    bus_state_t    state, after_ack;
    logic [3:0]    cnt;
    logic [7:0]    shreg;
    logic [7:0]    txb;
    logic [PW-1:0] ptr;
    logic          more;
    logic          byte_end;
    logic          bit_in;
    logic          ptr_ok;
    logic [7:0]    rd_byte;
    logic          wr_en;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cr_strap_decode #(.PREFIX(PREFIX)) u_strap (
        .pin_hi   (strap_hi),
        .pin_lo   (strap_lo),
        .dev_addr (dev_addr),
        .i2c_off  (i2c_off)
    );

    i2cr_regfile #(.NREG(NREG), .PW(PW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .mrst      (mrst),
        .wr_en     (wr_en),
        .wr_idx    (ptr),
        .wr_data   (shreg),
        .evt       (evt_i),
        .regs_flat (cfg_o),
        .irq       (irq_o)
    );

    assign bus_rst  = !rst_n || mrst;
    assign byte_end = scl_fall && (cnt == 4'd8);
    assign bit_in   = scl_rise && (cnt < 4'd8);
    assign ptr_ok   = ptr < PW'(NREG);

    // Select the byte to transmit: register at pointer, else filler.
    always_comb begin
        rd_byte = 8'hFF;
        for (int k = 0; k < NREG; k++)
            if (ptr == PW'(k)) rd_byte = cfg_o[8*k +: 8];
    end

    // Strobe a register write at the end of an in-range data byte.
    assign wr_en = !bus_rst && !i2c_off && !start_det && !stop_det
                   && (state == ST_WDAT) && byte_end && ptr_ok;

    // Protocol engine: address, pointer, data and acknowledge phases.
    always_ff @(posedge clk) begin
        if (bus_rst) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            txb       <= '0;
            ptr       <= '0;
            more      <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (i2c_off || stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (bit_in) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_end) begin
                        if (shreg[7:1] == dev_addr) begin
                            sda_oe    <= 1'b1;
                            state     <= ST_ACK;
                            after_ack <= shreg[0] ? ST_RDAT : ST_PTR;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_PTR: begin
                    if (bit_in) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_end) begin
                        if (shreg < 8'(NREG)) begin
                            ptr       <= shreg[PW-1:0];
                            sda_oe    <= 1'b1;
                            state     <= ST_ACK;
                            after_ack <= ST_WDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_WDAT: begin
                    if (bit_in) begin
                        shreg <= {shreg[6:0], sda_lvl};
                        cnt   <= cnt + 4'd1;
                    end else if (byte_end) begin
                        if (ptr_ok) begin
                            ptr       <= ptr + 1'b1;
                            sda_oe    <= 1'b1;
                            state     <= ST_ACK;
                            after_ack <= ST_WDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (after_ack == ST_RDAT) begin
                            txb    <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            if (ptr_ok) ptr <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                        state <= after_ack;
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (cnt < 4'd7) begin
                            sda_oe <= ~txb[6];
                            txb    <= {txb[6:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        more <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (more) begin
                            cnt    <= '0;
                            txb    <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            if (ptr_ok) ptr <= ptr + 1'b1;
                            state  <= ST_RDAT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(i2c_off) |-> !sda_oe); // R2
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !i2c_off && !mrst) |=> state == ST_ADDR); // R3
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe)); // R3
    AST_PTR_KEPT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !mrst) |=> $stable(ptr)); // R3
    AST_DRIVE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ACK || state == ST_RDAT)); // R5

endmodule

// File: tb/i2cr_target_bank_bench.sv
module i2cr_target_bank_bench;

    localparam int NREG = 9;
    localparam int Q    = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, mrst, scl, sda_m;
    logic [1:0]        shi, slo, evt;
    logic              sda_oe, irq;
    logic [NREG*8-1:0] cfg;
    logic              sda_line;

    assign sda_line = sda_m & ~sda_oe;

    i2cr_target_bank u_i2cr_target_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .mrst     (mrst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_hi (shi),
        .strap_lo (slo),
        .evt_i    (evt),
        .sda_oe   (sda_oe),
        .cfg_o    (cfg),
        .irq_o    (irq)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    bit   off_mode = 1'b0;
    bit   off_drive = 1'b0;
    logic [7:0] mdl [NREG];
    logic [6:0] dadr;

    // Stimulus table: {pointer, data} single-byte write then read-back.
    localparam logic [15:0] VEC [6] = '{16'h003C, 16'h01A5, 16'h02FF,
                                        16'h0300, 16'h055A, 16'h08C3};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] addr_of(input logic [1:0] h, input logic [1:0] l);
        int lh, ll;
        lh = (h == 2'b00) ? 0 : (h == 2'b10) ? 2 : 1;
        ll = (l == 2'b00) ? 0 : (l == 2'b10) ? 2 : 1;
        return {4'b1101, 3'(lh * 3 + ll)};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; idle(Q); scl = 1'b0; idle(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; idle(Q); scl = 1'b1; idle(Q);
        sda_m = 1'b0; idle(Q); scl = 1'b0; idle(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(Q); scl = 1'b1; idle(Q); sda_m = 1'b1; idle(2 * Q);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        sda_m = b; idle(Q); scl = 1'b1; idle(Q);
        s = sda_line; idle(Q); scl = 1'b0; idle(Q);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic last, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            d[i] = s;
        end
        bit_xfer(last, s);
    endtask

    task automatic reg_write1(input logic [7:0] p, input logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(p, a2); wbyte(d, a3); bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic reg_read1(input logic [7:0] p, output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(p, a2);
        bus_rstart(); wbyte({dadr, 1'b1}, a3); rbyte(1'b1, d); bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < NREG; k++) chk(req, 32'(cfg[8*k +: 8]), 32'(mdl[k]));
    endtask

    task automatic model_defaults();
        for (int k = 0; k < NREG; k++) mdl[k] = 8'h80 | 8'(k);
    endtask

    // Record any drive of SDA while the strap hands the port away.
    always @(negedge clk) if (off_mode && sda_oe) off_drive = 1'b1;

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL ALL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic       ok, a1, a2, a3;
        logic [7:0] d;
        rst_n = 1'b0; mrst = 1'b0; scl = 1'b1; sda_m = 1'b1;
        shi = 2'b00; slo = 2'b01; evt = 2'b00;
        dadr = addr_of(shi, slo);
        idle(5); rst_n = 1'b1; idle(5);

        // Reset state (R8, R10).
        model_defaults();
        check_bank("R8 reset defaults");
        chk("R10 irq after reset", 32'(irq), 0);
        chk("R3 bus idle released", 32'(sda_oe), 0);

        // Full sequential read from pointer 0 plus one filler (R7).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h00, a2);
        bus_rstart(); wbyte({dadr, 1'b1}, a3);
        chk("R1 ack own address", 32'(a1 & a3), 1);
        for (int k = 0; k <= NREG; k++) begin
            rbyte(k == NREG, d);
            chk("R7 stream read", 32'(d), (k < NREG) ? 32'(mdl[k]) : 32'hFF);
        end
        bus_stop();

        // Table of single writes with read-back (R5, R7).
        for (int v = 0; v < 6; v++) begin
            reg_write1(VEC[v][15:8], VEC[v][7:0], ok);
            mdl[VEC[v][15:8]] = VEC[v][7:0];
            chk("R5 write ack", 32'(ok), 1);
            chk("R5 cfg_o lane", 32'(cfg[8*VEC[v][15:8] +: 8]), 32'(VEC[v][7:0]));
            reg_read1(VEC[v][15:8], d, ok);
            chk("R7 read back", 32'(d), 32'(VEC[v][7:0]));
        end

        // Burst write with auto-increment, then burst read (R5, R7).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h02, a2);
        wbyte(8'h11, a1); wbyte(8'h22, a2); wbyte(8'h33, a3); bus_stop();
        mdl[2] = 8'h11; mdl[3] = 8'h22; mdl[4] = 8'h33;
        chk("R5 burst acks", 32'(a1 & a2 & a3), 1);
        check_bank("R5 burst contents");
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h02, a2);
        bus_rstart(); wbyte({dadr, 1'b1}, a3);
        for (int k = 0; k < 3; k++) begin
            rbyte(k == 2, d);
            chk("R7 burst read", 32'(d), 32'(mdl[2 + k]));
        end
        bus_stop();

        // Write at register 8 then past it (R6).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h08, a2);
        wbyte(8'h4E, a1); wbyte(8'hE4, a2); bus_stop();
        mdl[8] = 8'h4E;
        chk("R6 last reg ack", 32'(a1), 1);
        chk("R6 nack past end", 32'(a2), 0);
        check_bank("R6 bank unchanged past end");

        // Pointer out of range (R4).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h09, a2); wbyte(8'h77, a3); bus_stop();
        chk("R4 nack pointer 9", 32'(a2), 0);
        chk("R4 data ignored", 32'(a3), 0);
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h20, a2); bus_stop();
        chk("R4 nack pointer 0x20", 32'(a2), 0);
        check_bank("R4 bank unchanged");

        // Read across the end of the bank (R7).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h07, a2);
        bus_rstart(); wbyte({dadr, 1'b1}, a3);
        rbyte(1'b0, d); chk("R7 read CR7", 32'(d), 32'(mdl[7]));
        rbyte(1'b0, d); chk("R7 read CR8", 32'(d), 32'(mdl[8]));
        rbyte(1'b1, d); chk("R7 filler", 32'(d), 32'hFF);
        bus_stop();

        // Repeated START keeps the advanced pointer (R3).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h03, a2); wbyte(8'h99, a3);
        mdl[3] = 8'h99;
        bus_rstart(); wbyte({dadr, 1'b1}, a1); rbyte(1'b1, d); bus_stop();
        chk("R3 pointer kept over repeated start", 32'(d), 32'(mdl[4]));

        // Bits after STOP without START are ignored (R3).
        bus_start(); wbyte({dadr, 1'b0}, a1); wbyte(8'h01, a2); bus_stop();
        wbyte(8'hEE, a3); wbyte(8'hEE, a3);
        chk("R3 no ack after stop", 32'(a3), 0);
        sda_m = 1'b1; scl = 1'b1; idle(2 * Q);
        check_bank("R3 bank untouched after stop");

        // Strap decoding (R1) and hand-over combination (R2).
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: begin shi = 2'b00; slo = 2'b00; end
                1: begin shi = 2'b10; slo = 2'b01; end
                2: begin shi = 2'b01; slo = 2'b10; end
                default: begin shi = 2'b11; slo = 2'b00; end
            endcase
            idle(4);
            bus_start(); wbyte({addr_of(shi, slo), 1'b0}, a1); bus_stop();
            chk("R1 strap address ack", 32'(a1), 1);
            bus_start(); wbyte({addr_of(shi, slo) ^ 7'h01, 1'b0}, a1); bus_stop();
            chk("R1 other address nack", 32'(a1), 0);
        end
        shi = 2'b10; slo = 2'b10; idle(4); off_mode = 1'b1;
        bus_start(); wbyte({7'h68, 1'b0}, a1); bus_stop();
        chk("R2 silent 0x68", 32'(a1), 0);
        bus_start(); wbyte({7'h6F, 1'b0}, a2); bus_stop();
        chk("R2 silent 0x6F", 32'(a2), 0);
        off_mode = 1'b0;
        chk("R2 never drove SDA", 32'(off_drive), 0);
        shi = 2'b00; slo = 2'b01; idle(4);

        // Soft reset through register 6 bit 4 (R9).
        reg_write1(8'h06, 8'h10, ok);
        model_defaults();
        chk("R9 soft reset ack", 32'(ok), 1);
        check_bank("R9 defaults after soft reset");

        // Sticky event flags and interrupt (R10).
        evt = 2'b01; idle(2); evt = 2'b00; idle(2);
        chk("R10 irq on event", 32'(irq), 1);
        reg_read1(8'h07, d, ok);
        chk("R10 flag bit5 set", 32'(d), 32'hA7);
        reg_write1(8'h07, 8'h27, ok);
        idle(2);
        chk("R10 write-1-clear", 32'(cfg[8*7 +: 8]), 32'h07);
        chk("R10 irq cleared", 32'(irq), 0);

        // Master reset holds defaults and a quiet interrupt (R8, R10).
        reg_write1(8'h00, 8'h55, ok);
        chk("R5 pre-reset write", 32'(cfg[7:0]), 32'h55);
        evt = 2'b10; mrst = 1'b1; idle(4);
        model_defaults();
        chk("R10 irq low during mrst", 32'(irq), 0);
        check_bank("R8 defaults during mrst");
        mrst = 1'b0; idle(2); evt = 2'b00; idle(2);
        chk("R10 flag after mrst release", 32'(irq), 1);
        reg_read1(8'h07, d, ok);
        chk("R10 flag bit6 set", 32'(d), 32'hC7);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule